// File: doc/BRIEF.md
# Capture Trigger Unit

This unit watches a word of sampled digital channels and produces one trigger pulse when a programmed condition holds. Each clock cycle in which `smp_valid` is high carries one sample. An invert mask is applied to every sample first. Up to four condition slots then each test the result. A slot can look for a rising edge on one channel, a falling edge on one channel, or a masked match of the whole word against a pattern. The outputs of the participating slots are merged by AND, OR or XOR. An optional delay, counted in samples, can come between the match and the pulse.

Software sets the unit up through a write-only register port. An `arm` strobe starts a hunt. The unit fires at most once per arming and holds a `triggered` level until it is armed again. When triggering is disabled, arming alone makes the unit fire.

Top module: `ctrig_top`

## Requirements
- R1: After reset, `trig_pulse` and `triggered` are low, and no pulse appears before the first `arm` strobe, whatever samples arrive.
- R2: Slot kind code 0 (slot register at address 4+k, bits [1:0]; channel index in bits [7:4]) hits when the selected channel is 0 in the previous valid sample and 1 in the current one.
- R3: Slot kind code 1 hits when the selected channel is 1 in the previous valid sample and 0 in the current one. Kind code 3 never hits.
- R4: Slot kind code 2 hits when the sample equals the pattern (address 8+k) in every bit whose care mask bit (address 12+k) is 1. Bits whose mask bit is 0 are ignored.
- R5: The invert mask (address 1) is XORed into each sample before any edge or pattern test, so an inverted channel swaps rising and falling.
- R6: The count field (address 0, bits [6:4]) selects how many slots, starting from slot 0, take part. Slots at or above the count give 1 under AND and 0 under OR or XOR.
- R7: The function field (address 0, bits [2:1]) merges the participating slots: 0 = AND, 1 = OR, 2 = XOR.
- R8: With delay value D (address 2) equal to 0, `trig_pulse` rises in the cycle after the matching sample. With D > 0, it rises in the cycle after the D-th valid sample that follows the matching sample.
- R9: `trig_pulse` lasts one cycle and fires at most once per arming. `triggered` rises with it and stays high until the next `arm`, which clears it and starts a new hunt.
- R10: With the enable bit (address 0, bit 0) at 0, an `arm` strobe raises `trig_pulse` and `triggered` in the next cycle, whatever the samples are.
- R11: A cycle with `smp_valid` low is not evaluated. It does not count toward the delay and does not replace the previous sample used for edge detection.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration register address |
| cfg_wdata | input | N_CH (16) | Configuration write data |
| arm | input | 1 | Starts a new hunt; clears `triggered` |
| smp_valid | input | 1 | Marks `smp_data` as a sample |
| smp_data | input | N_CH (16) | Sampled channel word |
| trig_pulse | output | 1 | One-cycle trigger pulse |
| triggered | output | 1 | High from the pulse until the next arm |

## Verification
The assertions assume that software does not strobe `arm` in the cycle that directly follows a pulse. They also assume that configuration writes are finished before arming, because the unit reads its registers live. The directed stimulus writes all registers and then waits one cycle before each arm, and it never re-arms immediately after a pulse. Samples are applied only in the cycles between arm strobes, so every pulse can be traced back to one arm and one sample.

// File: rtl/ctrig_pkg.sv
package ctrig_pkg;

    typedef enum logic [1:0] {
        KIND_RISE = 2'd0,
        KIND_FALL = 2'd1,
        KIND_PAT  = 2'd2,
        KIND_NONE = 2'd3
    } kind_e;

    typedef enum logic [1:0] {
        FN_AND = 2'd0,
        FN_OR  = 2'd1,
        FN_XOR = 2'd2,
        FN_RSV = 2'd3
    } comb_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HUNT = 2'd1,
        ST_WAIT = 2'd2,
        ST_DONE = 2'd3
    } st_e;

    localparam int ADDR_W = 4;
    localparam int A_CTRL = 0;
    localparam int A_INV  = 1;
    localparam int A_DLY  = 2;
    localparam int A_SLOT = 4;
    localparam int A_PAT  = 8;
    localparam int A_MASK = 12;

endpackage

// File: rtl/ctrig_regs.sv
module ctrig_regs
    import ctrig_pkg::*;
#(
    parameter int N_CH   = 16,
    parameter int N_SLOT = 4,
    parameter int DLY_W  = 8,
    localparam int CH_IDX_W = $clog2(N_CH),
    localparam int CNT_W    = $clog2(N_SLOT + 1)
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               we,
    input  logic [ADDR_W-1:0]                  addr,
    input  logic [N_CH-1:0]                    wdata,
    output logic                               en,
    output comb_e                              fn,
    output logic [CNT_W-1:0]                   cnt,
    output logic [N_CH-1:0]                    inv,
    output logic [DLY_W-1:0]                   dly,
    output logic [N_SLOT-1:0][1:0]             kind,
    output logic [N_SLOT-1:0][CH_IDX_W-1:0]    chsel,
    output logic [N_SLOT-1:0][N_CH-1:0]        pat,
    output logic [N_SLOT-1:0][N_CH-1:0]        mask
);

    typedef struct packed {
        logic                            en;
        comb_e                           fn;
        logic [CNT_W-1:0]                cnt;
        logic [N_CH-1:0]                 inv;
        logic [DLY_W-1:0]                dly;
        logic [N_SLOT-1:0][1:0]          kind;
        logic [N_SLOT-1:0][CH_IDX_W-1:0] chsel;
        logic [N_SLOT-1:0][N_CH-1:0]     pat;
        logic [N_SLOT-1:0][N_CH-1:0]     mask;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (we) begin
            if (addr == ADDR_W'(A_CTRL)) begin
                r_d.en  = wdata[0];
                r_d.fn  = comb_e'(wdata[2:1]);
                r_d.cnt = wdata[4 +: CNT_W];
            end
            if (addr == ADDR_W'(A_INV)) begin
                r_d.inv = wdata;
            end
            if (addr == ADDR_W'(A_DLY)) begin
                r_d.dly = wdata[DLY_W-1:0];
            end
            for (int k = 0; k < N_SLOT; k++) begin
                if (addr == ADDR_W'(A_SLOT + k)) begin
                    r_d.kind[k]  = wdata[1:0];
                    r_d.chsel[k] = wdata[4 +: CH_IDX_W];
                end
                if (addr == ADDR_W'(A_PAT + k)) begin
                    r_d.pat[k] = wdata;
                end
                if (addr == ADDR_W'(A_MASK + k)) begin
                    r_d.mask[k] = wdata;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign en    = r_q.en;
    assign fn    = r_q.fn;
    assign cnt   = r_q.cnt;
    assign inv   = r_q.inv;
    assign dly   = r_q.dly;
    assign kind  = r_q.kind;
    assign chsel = r_q.chsel;
    assign pat   = r_q.pat;
    assign mask  = r_q.mask;

endmodule

// File: rtl/ctrig_slot.sv
module ctrig_slot
    import ctrig_pkg::*;
#(
    parameter int N_CH = 16,
    localparam int CH_IDX_W = $clog2(N_CH)
) (
    input  logic [1:0]          kind,
    input  logic [CH_IDX_W-1:0] chsel,
    input  logic [N_CH-1:0]     pat,
    input  logic [N_CH-1:0]     mask,
    input  logic [N_CH-1:0]     cur,
    input  logic [N_CH-1:0]     prv,
    input  logic                prv_ok,
    output logic                hit
);

    logic cur_bit, prv_bit;

    assign cur_bit = cur[chsel];
    assign prv_bit = prv[chsel];

    always_comb begin
        unique case (kind)
            KIND_RISE: hit = prv_ok & ~prv_bit & cur_bit;
            KIND_FALL: hit = prv_ok & prv_bit & ~cur_bit;
            KIND_PAT:  hit = ((cur ^ pat) & mask) == '0;
            default:   hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/ctrig_seq.sv
module ctrig_seq
    import ctrig_pkg::*;
#(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic             smp_valid,
    input  logic             en,
    input  logic             hit_all,
    input  logic [DLY_W-1:0] dly,
    output logic             pulse,
    output logic             triggered
);

    typedef struct packed {
        st_e              st;
        logic [DLY_W-1:0] cnt;
        logic             pulse;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.pulse = 1'b0;
        if (arm) begin
            if (!en) begin
                s_d.st    = ST_DONE;
                s_d.pulse = 1'b1;
            end else begin
                s_d.st = ST_HUNT;
            end
        end else begin
            unique case (s_q.st)
                ST_HUNT: begin
                    if (smp_valid && hit_all) begin
                        if (dly == '0) begin
                            s_d.st    = ST_DONE;
                            s_d.pulse = 1'b1;
                        end else begin
                            s_d.st  = ST_WAIT;
                            s_d.cnt = dly;
                        end
                    end
                end
                ST_WAIT: begin
                    if (smp_valid) begin
                        if (s_q.cnt == DLY_W'(1)) begin
                            s_d.st    = ST_DONE;
                            s_d.pulse = 1'b1;
                        end else begin
                            s_d.cnt = s_q.cnt - DLY_W'(1);
                        end
                    end
                end
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, cnt: '0, pulse: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign pulse     = s_q.pulse;
    assign triggered = (s_q.st == ST_DONE);

endmodule

// File: rtl/ctrig_top.sv
module ctrig_top
    import ctrig_pkg::*;
#(
    parameter int N_CH   = 16,
    parameter int N_SLOT = 4,
    parameter int DLY_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [3:0]        cfg_addr,
    input  logic [N_CH-1:0]   cfg_wdata,
    input  logic              arm,
    input  logic              smp_valid,
    input  logic [N_CH-1:0]   smp_data,
    output logic              trig_pulse,
    output logic              triggered
);

    localparam int CH_IDX_W = $clog2(N_CH);
    localparam int CNT_W    = $clog2(N_SLOT + 1);

    logic                            cfg_en;
    comb_e                           cfg_fn;
    logic [CNT_W-1:0]                cfg_cnt;
    logic [N_CH-1:0]                 cfg_inv;
    logic [DLY_W-1:0]                cfg_dly;
    logic [N_SLOT-1:0][1:0]          cfg_kind;
    logic [N_SLOT-1:0][CH_IDX_W-1:0] cfg_chsel;
    logic [N_SLOT-1:0][N_CH-1:0]     cfg_pat;
    logic [N_SLOT-1:0][N_CH-1:0]     cfg_mask;

    ctrig_regs #(.N_CH(N_CH), .N_SLOT(N_SLOT), .DLY_W(DLY_W)) i_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .en    (cfg_en),
        .fn    (cfg_fn),
        .cnt   (cfg_cnt),
        .inv   (cfg_inv),
        .dly   (cfg_dly),
        .kind  (cfg_kind),
        .chsel (cfg_chsel),
        .pat   (cfg_pat),
        .mask  (cfg_mask)
    );

    typedef struct packed {
        logic [N_CH-1:0] prv;
        logic            prv_ok;
    } hist_t;

    hist_t h_d, h_q;
    logic [N_CH-1:0] cur;

    assign cur = smp_data ^ cfg_inv;

    always_comb begin
        h_d = h_q;
        if (smp_valid) begin
            h_d.prv    = cur;
            h_d.prv_ok = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_q <= '0;
        end else begin
            h_q <= h_d;
        end
    end

    logic [N_SLOT-1:0] hit;

    for (genvar g = 0; g < N_SLOT; g++) begin : g_slot
        ctrig_slot #(.N_CH(N_CH)) i_slot (
            .kind   (cfg_kind[g]),
            .chsel  (cfg_chsel[g]),
            .pat    (cfg_pat[g]),
            .mask   (cfg_mask[g]),
            .cur    (cur),
            .prv    (h_q.prv),
            .prv_ok (h_q.prv_ok),
            .hit    (hit[g])
        );
    end

    logic [N_SLOT-1:0] eff;
    logic              ident;
    logic              hit_all;

    assign ident = (cfg_fn == FN_AND);

    always_comb begin
        for (int k = 0; k < N_SLOT; k++) begin
            eff[k] = (CNT_W'(k) < cfg_cnt) ? hit[k] : ident;
        end
        unique case (cfg_fn)
            FN_AND:  hit_all = &eff;
            FN_XOR:  hit_all = ^eff;
            default: hit_all = |eff;
        endcase
    end

    ctrig_seq #(.DLY_W(DLY_W)) i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm       (arm),
        .smp_valid (smp_valid),
        .en        (cfg_en),
        .hit_all   (hit_all),
        .dly       (cfg_dly),
        .pulse     (trig_pulse),
        .triggered (triggered)
    );

endmodule

// File: rtl/ctrig_checks.sv
module ctrig_checks (
    input logic clk,
    input logic rst_n,
    input logic arm,
    input logic smp_valid,
    input logic en,
    input logic trig_pulse,
    input logic triggered
);

    logic seen_arm_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_arm_q <= 1'b0;
        end else if (arm) begin
            seen_arm_q <= 1'b1;
        end
    end

    // R1: no pulse before the first arm
    assert_no_early_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
        trig_pulse |-> seen_arm_q);

    // R9: pulse lasts one cycle unless re-armed
    assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_pulse && !arm) |=> !trig_pulse);

    // R9: triggered level comes with the pulse and holds until arm
    assert_pulse_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
        trig_pulse |-> triggered);

    assert_level_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (triggered && !arm) |=> triggered);

    // R10: disabled unit fires on the cycle after arm
    assert_disabled_fire_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (arm && !en) |=> (trig_pulse && triggered));

    // R11: a pulse follows either an arm or a valid sample
    assert_pulse_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trig_pulse) |-> ($past(arm) || $past(smp_valid)));

endmodule

bind ctrig_top ctrig_checks i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .arm        (arm),
    .smp_valid  (smp_valid),
    .en         (cfg_en),
    .trig_pulse (trig_pulse),
    .triggered  (triggered)
);

// File: tb/test_ctrig_top.sv
`timescale 1ns/100ps
module test_ctrig_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic        arm = 1'b0;
    logic        smp_valid = 1'b0;
    logic [15:0] smp_data = '0;
    logic        trig_pulse;
    logic        triggered;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ctrig_top i_ctrig_top (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .arm        (arm),
        .smp_valid  (smp_valid),
        .smp_data   (smp_data),
        .trig_pulse (trig_pulse),
        .triggered  (triggered)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic expect_out(string req, bit ep, bit et);
        checks++;
        if (trig_pulse !== ep || triggered !== et) begin
            errors++;
            $display("FAIL %s: pulse/triggered actual %b/%b expected %b/%b",
                     req, trig_pulse, triggered, ep, et);
        end
    endtask

    task automatic wr(int a, int d);
        cfg_we    = 1'b1;
        cfg_addr  = 4'(a);
        cfg_wdata = 16'(d);
        step();
        cfg_we = 1'b0;
    endtask

    task automatic do_arm();
        arm = 1'b1;
        step();
        arm = 1'b0;
    endtask

    task automatic send(logic [15:0] w);
        smp_valid = 1'b1;
        smp_data  = w;
        step();
        smp_valid = 1'b0;
    endtask

    task automatic idle(logic [15:0] w);
        smp_valid = 1'b0;
        smp_data  = w;
        step();
    endtask

    task automatic t_reset();
        expect_out("R1 reset", 0, 0);
        wr(0, 'h01);
        send(16'h0000);
        send(16'h0008);
        expect_out("R1 no pulse before arm", 0, 0);
    endtask

    task automatic t_rise();
        wr(0, 'h13);
        wr(4, 'h30);
        step();
        do_arm();
        send(16'h0000);
        expect_out("R2 no edge", 0, 0);
        send(16'h0008);
        expect_out("R2 rising edge ch3", 1, 1);
        send(16'h0000);
        send(16'h0008);
        expect_out("R9 once per arm", 0, 1);
    endtask

    task automatic t_fall();
        wr(4, 'h51);
        step();
        do_arm();
        send(16'h0020);
        expect_out("R3 rising not falling", 0, 0);
        send(16'h0000);
        expect_out("R3 falling edge ch5", 1, 1);
    endtask

    task automatic t_pattern();
        wr(4, 'h02);
        wr(8, 'h00A5);
        wr(12, 'h00FF);
        step();
        do_arm();
        send(16'hFF5A);
        expect_out("R4 mismatch", 0, 0);
        send(16'h12A5);
        expect_out("R4 masked match", 1, 1);
    endtask

    task automatic t_invert();
        wr(1, 'h0003);
        wr(8, 'h00A6);
        step();
        do_arm();
        send(16'h00A6);
        expect_out("R5 raw word ignored", 0, 0);
        send(16'h00A5);
        expect_out("R5 inverted pattern match", 1, 1);
        wr(1, 'h0001);
        wr(4, 'h00);
        send(16'h0000);
        do_arm();
        send(16'h0001);
        expect_out("R5 raw rise is inverted fall", 0, 0);
        send(16'h0000);
        expect_out("R5 inverted rise", 1, 1);
        wr(1, 'h0000);
    endtask

    task automatic t_and();
        wr(0, 'h21);
        wr(4, 'h02);
        wr(8, 'h0001);
        wr(12, 'h0001);
        wr(5, 'h40);
        wr(6, 'h03);
        step();
        do_arm();
        send(16'h0000);
        send(16'h0010);
        expect_out("R7 AND one slot only", 0, 0);
        send(16'h0000);
        send(16'h0011);
        expect_out("R7 AND both slots; R6 slot2 identity", 1, 1);
    endtask

    task automatic t_count();
        wr(0, 'h13);
        wr(4, 'h03);
        step();
        do_arm();
        send(16'h0000);
        send(16'h0010);
        expect_out("R6 slot beyond count excluded", 0, 0);
        wr(0, 'h01);
        step();
        do_arm();
        send(16'h0000);
        expect_out("R6 zero slots under AND", 1, 1);
    endtask

    task automatic t_xor();
        wr(0, 'h25);
        wr(4, 'h02);
        wr(5, 'h02);
        wr(9, 'h0002);
        wr(13, 'h0002);
        step();
        do_arm();
        send(16'h0003);
        expect_out("R7 XOR both hit", 0, 0);
        send(16'h0002);
        expect_out("R7 XOR one hit", 1, 1);
    endtask

    task automatic t_delay();
        wr(0, 'h13);
        wr(2, 3);
        step();
        do_arm();
        send(16'h0001);
        expect_out("R8 delayed, match sample", 0, 0);
        send(16'h0000);
        expect_out("R8 delay sample 1", 0, 0);
        idle(16'h0000);
        expect_out("R11 invalid cycle not counted", 0, 0);
        send(16'h0000);
        expect_out("R8 delay sample 2", 0, 0);
        send(16'h0000);
        expect_out("R8 delay sample 3 fires", 1, 1);
        idle(16'h0000);
        expect_out("R9 pulse one cycle", 0, 1);
        wr(2, 0);
    endtask

    task automatic t_disabled();
        wr(0, 'h00);
        step();
        do_arm();
        expect_out("R10 disabled fires on arm", 1, 1);
        step();
        expect_out("R10 single pulse", 0, 1);
    endtask

    task automatic t_rearm();
        wr(0, 'h13);
        wr(4, 'h30);
        step();
        do_arm();
        expect_out("R9 arm clears triggered", 0, 0);
        send(16'h0000);
        idle(16'h0008);
        expect_out("R11 invalid sample ignored", 0, 0);
        send(16'h0008);
        expect_out("R9 re-armed fires; R11 previous kept", 1, 1);
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        step();
        t_reset();
        t_rise();
        t_fall();
        t_pattern();
        t_invert();
        t_and();
        t_count();
        t_xor();
        t_delay();
        t_disabled();
        t_rearm();
        repeat (3) step();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule